// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Bus Link

This block joins a bus-issuing controller and a responding register target with a fully interlocked request/acknowledge exchange. Each side treats the other side's strobe as an asynchronous input and samples it through a chain of flip-flops before acting on it. A transfer is therefore correct whatever the relative speed of the two sides. On the issuing side, a command is accepted from a local port. The issuer places address, direction and write data on the link and holds them for a set number of decode cycles so that the target can recognise its address. Only then does it raise the request strobe.

The target compares the upper address bits with its base. On a write it stores the data word before it acknowledges. On a read it drives the addressed word and keeps it driven until the request falls. The issuer drops its request once it sees the acknowledge, and it samples read data in that same cycle. The transfer is finished when the issuer then sees the acknowledge fall. If no acknowledge arrives within a set number of cycles, the issuer gives up and reports a timeout instead of completing.

Top module: `fourphase_link`

## Requirements
- R1: After reset, cmd_ready is 1, done is 0, timeout is 0 and rdata is 0.
- R2: A command is taken at a rising edge where cmd_ready and cmd_valid are both 1. cmd_ready is 0 from the next cycle until the transfer ends. cmd_valid, cmd_write, cmd_addr and cmd_wdata are ignored while cmd_ready is 0.
- R3: The request rises exactly DECODE_CYC cycles after the address is driven. The strobes follow the order request up, acknowledge up, request down, acknowledge down. Address, direction and write data stay unchanged while the request is high.
- R4: A write (cmd_write = 1) to an address whose bits above the low log2(SLV_WORDS) bits equal those of SLV_BASE stores cmd_wdata in the word selected by the low log2(SLV_WORDS) address bits. A later read of that word returns the stored value.
- R5: A completed read (cmd_write = 0) loads rdata with the addressed word, captured in the cycle the request is dropped. rdata then holds its value through writes and through timed-out transfers.
- R6: On a completed transfer, done is high for exactly one cycle, DECODE_CYC + 4*SYNC_STAGES + 4 cycles after the accepting edge. cmd_ready returns to 1 in that same cycle. done and timeout are never high together.
- R7: For an address outside the target's window, no acknowledge is given. timeout is high for one cycle, DECODE_CYC + TIMEOUT_CYC cycles after the accepting edge, and done stays low. cmd_ready returns one cycle later, and target storage is left unchanged.
- R8: When the acknowledge is seen in the same cycle that the timeout window expires (TIMEOUT_CYC = 2*SYNC_STAGES + 2), the acknowledge wins: the transfer completes with done and without timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Transfer address |
| cmd_wdata | input | DATA_W | Write data |
| cmd_ready | output | 1 | Issuer idle, command may be taken |
| done | output | 1 | One-cycle pulse on completed transfer |
| timeout | output | 1 | One-cycle pulse when no acknowledge came |
| rdata | output | DATA_W | Last completed read data |

## Verification
Two functions can fall in the same cycle: the issuer's first sight of the synchronized acknowledge and the expiry of its timeout window. A second instance is built with TIMEOUT_CYC equal to 2*SYNC_STAGES + 2, so that for a matched read the acknowledge arrives in exactly the cycle the window runs out. It is judged by requiring done at the normal latency, no timeout pulse in any cycle, and the correct read word. A second overlap, a new command offered while the link is busy, is provoked by holding cmd_valid with different data for two cycles after acceptance. It is judged by reading back the target word afterwards.

// File: rtl/fp_pkg.sv
package fp_pkg;
   typedef enum logic [1:0] {
      M_IDLE,
      M_DECODE,
      M_REQ,
      M_WAIT_LOW
   } mst_state_t;

   typedef enum logic {
      S_IDLE,
      S_ACK
   } slv_state_t;
endpackage

// File: rtl/fp_sync.sv
module fp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial assert (STAGES >= 2) else $error("fp_sync: STAGES must be at least 2");

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/fp_master.sv
module fp_master
   import fp_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int DECODE_CYC  = 2,
   parameter int TIMEOUT_CYC = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              cmd_ready,
   output logic              done,
   output logic              timeout,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_write,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              req,
   input  logic              ack_s
);
   localparam int CW = $clog2(DECODE_CYC + TIMEOUT_CYC + 1);

   initial assert (DECODE_CYC >= 1) else $error("fp_master: DECODE_CYC must be at least 1");
   initial assert (TIMEOUT_CYC >= 2) else $error("fp_master: TIMEOUT_CYC too small");

   mst_state_t    state;
   logic [CW-1:0] cnt;
   logic          failed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= M_IDLE;
         cnt       <= '0;
         failed    <= 1'b0;
         req       <= 1'b0;
         done      <= 1'b0;
         timeout   <= 1'b0;
         rdata     <= '0;
         bus_addr  <= '0;
         bus_write <= 1'b0;
         bus_wdata <= '0;
      end else begin
         done    <= 1'b0;
         timeout <= 1'b0;
         case (state)
            M_IDLE: begin
               if (cmd_valid) begin
                  bus_addr  <= cmd_addr;
                  bus_write <= cmd_write;
                  bus_wdata <= cmd_wdata;
                  cnt       <= CW'(DECODE_CYC - 1);
                  state     <= M_DECODE;
               end
            end
            M_DECODE: begin
               if (cnt == '0) begin
                  req   <= 1'b1;
                  state <= M_REQ;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            M_REQ: begin
               if (ack_s) begin
                  req    <= 1'b0;
                  failed <= 1'b0;
                  if (!bus_write) rdata <= bus_rdata;
                  state  <= M_WAIT_LOW;
               end else if (cnt == CW'(TIMEOUT_CYC - 1)) begin
                  req     <= 1'b0;
                  failed  <= 1'b1;
                  timeout <= 1'b1;
                  state   <= M_WAIT_LOW;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            M_WAIT_LOW: begin
               if (!ack_s) begin
                  done  <= !failed;
                  state <= M_IDLE;
               end
            end
            default: state <= M_IDLE;
         endcase
      end
   end

   assign cmd_ready = (state == M_IDLE);

   AST_BUS_STABLE_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (req && $past(req)) |-> ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write))); // R3
   AST_REQ_AFTER_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> !ack_s); // R3
   AST_REQ_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> $stable(bus_addr)); // R3
   AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> !timeout); // R7
   AST_DONE_XOR_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && timeout)); // R6
endmodule

// File: rtl/fp_slave.sv
module fp_slave
   import fp_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int WORDS  = 4,
   parameter int BASE   = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_write,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              req_s,
   output logic              ack
);
   localparam int IW = $clog2(WORDS);
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);

   initial assert (WORDS >= 2 && (1 << IW) == WORDS) else $error("fp_slave: WORDS must be a power of two >= 2");
   initial assert ((BASE % WORDS) == 0) else $error("fp_slave: BASE must be aligned to WORDS");
   initial assert (IW < ADDR_W) else $error("fp_slave: window wider than address");

   slv_state_t        state;
   logic [DATA_W-1:0] mem [WORDS];
   logic [DATA_W-1:0] rd_q;
   logic              rd_en;
   logic              hit;
   logic [IW-1:0]     idx;

   assign hit = (bus_addr[ADDR_W-1:IW] == BASE_V[ADDR_W-1:IW]);
   assign idx = bus_addr[IW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         ack   <= 1'b0;
         rd_en <= 1'b0;
         rd_q  <= '0;
         for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      end else begin
         case (state)
            S_IDLE: begin
               if (req_s && hit) begin
                  if (bus_write) mem[idx] <= bus_wdata;
                  else           rd_q     <= mem[idx];
                  rd_en <= !bus_write;
                  ack   <= 1'b1;
                  state <= S_ACK;
               end
            end
            S_ACK: begin
               if (!req_s) begin
                  ack   <= 1'b0;
                  rd_en <= 1'b0;
                  state <= S_IDLE;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign bus_rdata = rd_en ? rd_q : '0;

   AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> req_s); // R3
   AST_ACK_DROPS_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack) |-> !req_s); // R3
   AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && $past(ack) && !bus_write) |-> $stable(bus_rdata)); // R5
   AST_NO_ACK_OFF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> hit); // R7
endmodule

// File: rtl/fourphase_link.sv
module fourphase_link #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int DECODE_CYC  = 2,
   parameter int TIMEOUT_CYC = 16,
   parameter int SYNC_STAGES = 2,
   parameter int SLV_WORDS   = 4,
   parameter int SLV_BASE    = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              cmd_ready,
   output logic              done,
   output logic              timeout,
   output logic [DATA_W-1:0] rdata
);
   localparam int ACK_SEEN = 2 * SYNC_STAGES + 2;

   initial assert (TIMEOUT_CYC >= ACK_SEEN)
      else $error("fourphase_link: TIMEOUT_CYC shorter than round trip");

   logic [ADDR_W-1:0] bus_addr;
   logic              bus_write;
   logic [DATA_W-1:0] bus_wdata;
   logic [DATA_W-1:0] bus_rdata;
   logic              req, req_s, ack, ack_s;

   fp_master #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .DECODE_CYC(DECODE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
   ) u_master (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .cmd_ready(cmd_ready), .done(done), .timeout(timeout), .rdata(rdata),
      .bus_addr(bus_addr), .bus_write(bus_write), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .req(req), .ack_s(ack_s)
   );

   fp_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d(req), .q(req_s)
   );

   fp_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(ack), .q(ack_s)
   );

   fp_slave #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .WORDS(SLV_WORDS), .BASE(SLV_BASE)
   ) u_slave (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_write(bus_write), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .req_s(req_s), .ack(ack)
   );
endmodule

// File: tb/test_fourphase_link.sv
`timescale 1ns/1ps
module test_fourphase_link;
   localparam int D   = 2;
   localparam int T   = 16;
   localparam int S   = 2;
   localparam int LAT = D + 4*S + 4;
   localparam int TO  = D + T;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0, cmd_write = 1'b0;
   logic [7:0] cmd_addr = '0, cmd_wdata = '0;
   logic       cmd_ready, done, timeout;
   logic [7:0] rdata;

   logic       e_valid = 1'b0;
   logic [7:0] e_addr = '0;
   logic       e_ready, e_done, e_timeout;
   logic [7:0] e_rdata;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;
   int exp_mem [4];
   int exp_rdata = 0;

   always #5 clk = ~clk;

   fourphase_link #(.DECODE_CYC(D), .TIMEOUT_CYC(T), .SYNC_STAGES(S)) i_fourphase_link (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
      .done(done), .timeout(timeout), .rdata(rdata)
   );

   fourphase_link #(.DECODE_CYC(D), .TIMEOUT_CYC(2*S+2), .SYNC_STAGES(S)) i_fourphase_link_edge (
      .clk(clk), .rst_n(rst_n), .cmd_valid(e_valid), .cmd_write(1'b0),
      .cmd_addr(e_addr), .cmd_wdata(8'h00), .cmd_ready(e_ready),
      .done(e_done), .timeout(e_timeout), .rdata(e_rdata)
   );

   task automatic chk(input string tag, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference model: one transfer, compared every cycle against expected timing
   task automatic run_txn(input bit wr, input logic [7:0] a, input logic [7:0] d, input bit noise);
      bit hit = (a[7:2] == 6'h10);
      int last = hit ? LAT : TO + 1;
      @(negedge clk);
      chk("R2 ready before accept", cmd_ready, 1);
      cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
      @(posedge clk);
      @(negedge clk);
      if (noise) begin
         cmd_write = 1'b1; cmd_addr = {6'h10, a[1:0]}; cmd_wdata = ~d;
      end else cmd_valid = 1'b0;
      for (int k = 1; k <= last; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (k >= 2) cmd_valid = 1'b0;
         chk(hit ? "R6 done timing" : "R7 no done", done, (hit && k == LAT) ? 1 : 0);
         chk(hit ? "R6 no timeout" : "R7 timeout timing", timeout, (!hit && k == TO) ? 1 : 0);
         chk("R2 ready while busy", cmd_ready, (k == last) ? 1 : 0);
      end
      if (hit) begin
         if (wr) exp_mem[a[1:0]] = d;
         else    exp_rdata = exp_mem[a[1:0]];
      end
      chk(wr ? "R4 rdata kept on write" : "R5 read data", rdata, exp_rdata);
   endtask

   initial begin
      foreach (exp_mem[i]) exp_mem[i] = 0;
      repeat (3) @(negedge clk);
      chk("R1 ready", cmd_ready, 1);
      chk("R1 done", done, 0);
      chk("R1 timeout", timeout, 0);
      chk("R1 rdata", rdata, 0);
      rst_n = 1'b1;
      @(negedge clk);

      run_txn(1'b1, 8'h40, 8'hA5, 1'b0);   // R4
      run_txn(1'b1, 8'h43, 8'h3C, 1'b0);   // R4
      run_txn(1'b0, 8'h43, 8'h00, 1'b0);   // R5
      run_txn(1'b0, 8'h40, 8'h00, 1'b0);   // R5
      run_txn(1'b0, 8'h41, 8'h00, 1'b0);   // R5 untouched word
      run_txn(1'b1, 8'h42, 8'h77, 1'b1);   // R2 busy-time command ignored
      run_txn(1'b0, 8'h42, 8'h00, 1'b0);   // R2 readback shows 77 not 88
      run_txn(1'b0, 8'h40, 8'h00, 1'b0);
      run_txn(1'b1, 8'h81, 8'hEE, 1'b0);   // R7 out of window write
      run_txn(1'b0, 8'h10, 8'h00, 1'b0);   // R7 out of window read, rdata kept
      run_txn(1'b0, 8'h41, 8'h00, 1'b0);   // R7 storage unchanged (0x81 aliases word 1)
      run_txn(1'b0, 8'h43, 8'h00, 1'b0);

      // R8: acknowledge seen in the cycle the window expires
      @(negedge clk);
      e_valid = 1'b1; e_addr = 8'h43;
      @(posedge clk);
      @(negedge clk);
      e_valid = 1'b0;
      for (int k = 1; k <= LAT; k++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R8 done on coincidence", e_done, (k == LAT) ? 1 : 0);
         chk("R8 no timeout on coincidence", e_timeout, 0);
      end
      chk("R8 read data", e_rdata, 0);
      chk("R8 ready", e_ready, 1);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #2000000;
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule